// File: doc/BRIEF.md
# Programmable Interrupt Timer Bank

This block holds a set of independent down-counting timers. Each timer raises an interrupt request toward an interrupt controller, and each request carries its own vector, priority and destination processor mask. Software sets the timers up through a simple word-addressed register bus. Writes take effect at the clock edge, and reads are combinational from the address.

A single count-enable strobe advances every timer that is not inhibited. Each timer exposes four words:

- **Current count** (read-only): the 31-bit count, with a toggle flag in bit 31.
- **Base count**: the 31-bit reload value, with a count-inhibit flag in bit 31.
- **Vector/priority**: the mask, the read-only activity flag, the priority and the vector.
- **Destination**: the processor mask.

When a timer counts through zero, it reloads from its base count, flips its toggle flag and, if unmasked, raises its request. The request stays up until the consumer pulses that timer's acknowledge input.

A separate 32-bit frequency word is stored only so that software can read it back. A value of zero means the frequency is not set. The request side uses plain level signals, not a stream handshake. A request is held high while pending and takes no back-pressure. The acknowledge is a one-cycle pulse.

Top module: `tmr_bank`

## Requirements
- R1: After reset every timer's current count reads 0x00000000, base count 0x80000000 (inhibited), vector/priority 0x80000000 (masked), destination 0; the frequency word reads 0 and all requests are low.
- R2: Word address 4*t+f selects timer t, field f (f=0 current count, 1 base count, 2 vector/priority, 3 destination). A base-count write whose low 31 bits differ from the stored base loads them into the current count and clears the toggle (bit 31 of the current count word); bit 31 of the written word sets the inhibit flag.
- R3: While a timer is not inhibited, each cycle with cnt_en high decrements a nonzero current count by one; without cnt_en the count holds.
- R4: While inhibited the current count and toggle hold through strobes. A base-count write with an unchanged count field only changes the inhibit flag, so clearing inhibit resumes from the frozen count.
- R5: A strobe that finds the count at zero reloads the base count and flips the toggle, giving a period of base+1 strobes.
- R6: Vector/priority layout: bit 31 mask, bit 30 activity (read-only), bits 19:16 priority, bits 7:0 vector, other bits read 0. An expiry while masked raises no request, though the reload and toggle still happen.
- R7: An unmasked expiry raises irq_req[t]; it and the activity bit stay high until an irq_ack[t] pulse clears them; irq_vec, irq_pri and irq_dest carry the timer's vector, priority and destination.
- R8: The destination word stores NUM_CPU bits (others read 0); the frequency word at address 4*NUM_TMR stores all 32 bits; writes to a current-count word are ignored and unmapped addresses read 0.
- R9: Timers are independent: strobes and writes to one timer leave an inhibited neighbour's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wen | input | 1 | Write enable for the addressed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data of the addressed word |
| cnt_en | input | 1 | Count-enable strobe for all timers |
| irq_ack | input | NUM_TMR | Per-timer acknowledge pulse |
| irq_req | output | NUM_TMR | Per-timer pending request |
| irq_vec | output | NUM_TMR*8 | Vectors, timer t in bits 8t+7:8t |
| irq_pri | output | NUM_TMR*4 | Priorities, timer t in bits 4t+3:4t |
| irq_dest | output | NUM_TMR*NUM_CPU | Destination masks, timer t in slice t |

## Verification
The assertions check on every cycle the following properties:

- A decrement is exactly one step.
- An inhibited timer holds its count.
- Zero reloads from the base with a toggle flip.
- A masked timer never starts a request.
- An acknowledge without a simultaneous expiry clears the request.
- The frequency word changes only when written.

Only the bench's scenarios can show the following:

- The register map and field placement as seen on reads.
- The rule that a same-value base write does not reload.
- The full period and toggle sequence over several reloads.
- The reset values.
- The separation between timers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    FLD_CUR  = 2'd0,
    FLD_BASE = 2'd1,
    FLD_VP   = 2'd2,
    FLD_DST  = 2'd3
  } tmr_fld_e;

  localparam int VP_MASK_BIT = 31;
  localparam int VP_ACT_BIT  = 30;
  localparam int PRI_LSB     = 16;
  localparam int PRI_W       = 4;
  localparam int VEC_W       = 8;
  localparam logic [31:0] VP_WMASK = 32'h800F_00FF;
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_CPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic               wr_en,
  input  tmr_fld_e           wr_fld,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ack,
  output logic [DATA_W-1:0]  rd_cur,
  output logic [DATA_W-1:0]  rd_base,
  output logic [DATA_W-1:0]  rd_vp,
  output logic [DATA_W-1:0]  rd_dst,
  output logic               irq,
  output logic [VEC_W-1:0]   vec,
  output logic [PRI_W-1:0]   pri,
  output logic [NUM_CPU-1:0] dest
);
  localparam int CNT_W = DATA_W - 1;

  logic [CNT_W-1:0]  cur_q, base_q;
  logic              tgl_q, inh_q, pend_q;
  logic [DATA_W-1:0] vp_q;
  logic [NUM_CPU-1:0] dst_q;

  logic base_we, vp_we, dst_we, reload_wr, tick, at_zero, expire, masked;

  assign base_we   = wr_en && (wr_fld == FLD_BASE);
  assign vp_we     = wr_en && (wr_fld == FLD_VP);
  assign dst_we    = wr_en && (wr_fld == FLD_DST);
  assign reload_wr = wr_data[CNT_W-1:0] != base_q;
  assign tick      = cnt_en && !inh_q && !base_we;
  assign at_zero   = cur_q == '0;
  assign expire    = tick && at_zero;
  assign masked    = vp_q[VP_MASK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      tgl_q  <= 1'b0;
      inh_q  <= 1'b1;
    end else if (base_we) begin
      inh_q  <= wr_data[DATA_W-1];
      base_q <= wr_data[CNT_W-1:0];
      if (reload_wr) begin
        cur_q <= wr_data[CNT_W-1:0];
        tgl_q <= 1'b0;
      end
    end else if (tick) begin
      if (at_zero) begin
        cur_q <= base_q;
        tgl_q <= !tgl_q;
      end else begin
        cur_q <= cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_q  <= VP_WMASK & (32'h1 << VP_MASK_BIT);
      dst_q <= '0;
    end else begin
      if (vp_we)  vp_q  <= wr_data & VP_WMASK;
      if (dst_we) dst_q <= wr_data[NUM_CPU-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (expire && !masked) pend_q <= 1'b1;
    else if (ack)               pend_q <= 1'b0;
  end

  always_comb begin
    rd_vp             = vp_q;
    rd_vp[VP_ACT_BIT] = pend_q;
  end

  assign rd_cur  = {tgl_q, cur_q};
  assign rd_base = {inh_q, base_q};
  assign rd_dst  = {{(DATA_W-NUM_CPU){1'b0}}, dst_q};
  assign irq     = pend_q;
  assign vec     = vp_q[VEC_W-1:0];
  assign pri     = vp_q[PRI_LSB +: PRI_W];
  assign dest    = dst_q;

  AST_DEC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero) |=> (cur_q == $past(cur_q) - 1'b1)); // R3
  AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && !base_we) |=> ($stable(cur_q) && $stable(tgl_q))); // R4
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero) |=> (cur_q == $past(base_q) && tgl_q != $past(tgl_q))); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !pend_q) |=> !pend_q); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !irq); // R7
endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_wen,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  rd_cur,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  rd_base,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  rd_vp,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  rd_dst,
  input  logic [DATA_W-1:0]               freq_q,
  output logic [NUM_TMR-1:0]              tmr_wen,
  output tmr_fld_e                        fld,
  output logic                            freq_we,
  output logic [DATA_W-1:0]               rdata
);
  localparam int IDX_W    = $clog2(NUM_TMR);
  localparam int TMR_SPAN = NUM_TMR * 4;

  logic             in_tmr, is_freq;
  logic [IDX_W-1:0] idx;

  assign in_tmr  = bus_addr < ADDR_W'(TMR_SPAN);
  assign is_freq = bus_addr == ADDR_W'(TMR_SPAN);
  assign idx     = bus_addr[IDX_W+1:2];
  assign fld     = tmr_fld_e'(bus_addr[1:0]);
  assign freq_we = bus_wen && is_freq;

  always_comb begin
    tmr_wen = '0;
    if (bus_wen && in_tmr) tmr_wen[idx] = 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (in_tmr) begin
      unique case (fld)
        FLD_CUR:  rdata = rd_cur[idx];
        FLD_BASE: rdata = rd_base[idx];
        FLD_VP:   rdata = rd_vp[idx];
        FLD_DST:  rdata = rd_dst[idx];
      endcase
    end else if (is_freq) begin
      rdata = freq_q;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wen,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         cnt_en,
  input  logic [NUM_TMR-1:0]           irq_ack,
  output logic [NUM_TMR-1:0]           irq_req,
  output logic [NUM_TMR*VEC_W-1:0]     irq_vec,
  output logic [NUM_TMR*PRI_W-1:0]     irq_pri,
  output logic [NUM_TMR*NUM_CPU-1:0]   irq_dest
);
  logic [NUM_TMR-1:0][DATA_W-1:0] rd_cur, rd_base, rd_vp, rd_dst;
  logic [NUM_TMR-1:0] tmr_wen;
  tmr_fld_e           fld;
  logic               freq_we;
  logic [DATA_W-1:0]  freq_q;

  tmr_regdec #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_addr(bus_addr), .bus_wen(bus_wen),
    .rd_cur(rd_cur), .rd_base(rd_base), .rd_vp(rd_vp), .rd_dst(rd_dst),
    .freq_q(freq_q), .tmr_wen(tmr_wen), .fld(fld), .freq_we(freq_we),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       freq_q <= '0;
    else if (freq_we) freq_q <= bus_wdata;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    tmr_unit #(.DATA_W(DATA_W), .NUM_CPU(NUM_CPU)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .wr_en(tmr_wen[t]), .wr_fld(fld), .wr_data(bus_wdata), .ack(irq_ack[t]),
      .rd_cur(rd_cur[t]), .rd_base(rd_base[t]), .rd_vp(rd_vp[t]), .rd_dst(rd_dst[t]),
      .irq(irq_req[t]),
      .vec(irq_vec[t*VEC_W +: VEC_W]),
      .pri(irq_pri[t*PRI_W +: PRI_W]),
      .dest(irq_dest[t*NUM_CPU +: NUM_CPU])
    );
  end

  AST_FREQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_we |=> $stable(freq_q)); // R8
endmodule

// File: tb/test_tmr_bank.sv
`timescale 1ns/1ps
module test_tmr_bank;
  localparam int NT = 4;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cnt_en = 1'b0;
  logic [NT-1:0] irq_ack = '0;
  logic [NT-1:0] irq_req;
  logic [NT*8-1:0]  irq_vec;
  logic [NT*4-1:0]  irq_pri;
  logic [NT*NC-1:0] irq_dest;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = !clk;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_pri(irq_pri), .irq_dest(irq_dest)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic strobe();
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
  endtask

  task automatic ack(input int t);
    @(negedge clk); irq_ack[t] = 1'b1;
    @(negedge clk); irq_ack = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int t = 0; t < NT; t++) begin
      rd(4*t+0, v); chk("R1 cur", v, 32'h0);
      rd(4*t+1, v); chk("R1 base", v, 32'h8000_0000);
      rd(4*t+2, v); chk("R1 vp", v, 32'h8000_0000);
      rd(4*t+3, v); chk("R1 dst", v, 32'h0);
    end
    rd(16, v); chk("R1 freq", v, 32'h0);
    chk("R1 irq", 32'(irq_req), 32'h0);

    // R8 storage and ignored writes
    wr(16, 32'h0BEB_C200); rd(16, v); chk("R8 freq", v, 32'h0BEB_C200);
    for (int t = 0; t < NT; t++) begin
      wr(4*t+3, 32'hFFFF_FFF0 | 32'(t+9));
      rd(4*t+3, v); chk("R8 dst", v, 32'((t+9) & 15));
      chk("R7 dest out", 32'(irq_dest[t*NC +: NC]), 32'((t+9) & 15));
      wr(4*t+0, 32'h1234);
      rd(4*t+0, v); chk("R8 cur ro", v, 32'h0);
    end
    rd(17, v); chk("R8 unmapped", v, 32'h0);
    wr(17, 32'hFFFF_FFFF); rd(16, v); chk("R8 freq kept", v, 32'h0BEB_C200);

    // R2/R3/R5/R7/R9 sweep
    for (int t = 0; t < NT; t++) begin
      for (int b = 0; b <= 5; b++) begin
        logic [31:0] vp;
        vp = {1'b0, 11'h7FF, 4'((t + b) & 15), 8'hFF, 8'(8'h40 + t)};
        wr(4*t+2, vp);
        rd(4*t+2, v); chk("R6 vp layout", v, vp & 32'h000F_00FF);
        wr(4*t+1, 32'(b));
        rd(4*t+0, v); chk("R2 load", v, 32'(b));
        rd(4*t+1, v); chk("R2 base", v, 32'(b));
        repeat (2) @(negedge clk);
        rd(4*t+0, v); chk("R3 idle hold", v, 32'(b));
        for (int k = 1; k <= 2*(b+1)+1; k++) begin
          logic [31:0] e;
          strobe();
          e = 32'(b - (k % (b+1)));
          if (((k / (b+1)) & 1) != 0) e[31] = 1'b1;
          rd(4*t+0, v); chk("R3 R5 count", v, e);
          chk("R7 req", 32'(irq_req[t]), 32'(k >= b+1));
          if (t > 0) begin
            rd(4*(t-1)+0, v); chk("R9 neighbour", v[30:0], 32'(5 - ((2*6+1) % 6)));
          end
        end
        chk("R7 vec", 32'(irq_vec[t*8 +: 8]), 32'(8'h40 + t));
        chk("R7 pri", 32'(irq_pri[t*4 +: 4]), 32'((t + b) & 15));
        rd(4*t+2, v); chk("R7 active", v, (vp & 32'h000F_00FF) | 32'h4000_0000);
        ack(t);
        chk("R7 ack clr", 32'(irq_req[t]), 32'h0);
        rd(4*t+2, v); chk("R7 inactive", v, vp & 32'h000F_00FF);
      end
      wr(4*t+1, 32'h8000_0005);
    end

    // R4 inhibit freeze and resume, R2 rewrite while counting
    wr(1, 32'd10);
    repeat (3) strobe();
    rd(0, v); chk("R4 before", v, 32'd7);
    wr(1, 32'h8000_000A);
    repeat (4) strobe();
    rd(0, v); chk("R4 frozen", v, 32'd7);
    rd(1, v); chk("R4 inh bit", v, 32'h8000_000A);
    wr(1, 32'h0000_000A);
    repeat (2) strobe();
    rd(0, v); chk("R4 resume", v, 32'd5);
    wr(1, 32'd20);
    rd(0, v); chk("R2 reload", v, 32'd20);

    // R6 masked expiry
    wr(6, 32'h8000_0011);
    wr(5, 32'd1);
    repeat (2) strobe();
    rd(4, v); chk("R6 masked toggle", v, 32'h8000_0001);
    chk("R6 no req", 32'(irq_req[1]), 32'h0);
    rd(6, v); chk("R6 no act", v, 32'h8000_0011);

    finish_run();
  end
endmodule